// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block decides, for a five-stage in-order pipeline, when an instruction must be abandoned in favour of a handler. Each stage reports only what it sees locally: a bad instruction address at fetch, an undefined opcode at decode, an arithmetic overflow at execute, or a bad data address at memory. The block carries these reports down the pipe alongside each instruction in its own shadow registers. It acts on them only when the instruction reaches the memory stage, which is the single commit point.

At commit, pending external interrupt lines are examined. They are accepted only when interrupts are enabled and a real instruction occupies the memory stage, and they beat any synchronous fault. A taken event does four things: it raises kill lines for every stage and for writeback, steers the next PC to a fixed handler address, records a cause code and the faulting PC, and switches to kernel mode with interrupts masked. A return-from-exception reaching commit does the reverse: it restores user mode, unmasks interrupts and resumes at the saved PC.

The pipeline is assumed to advance every cycle. The decode, execute and memory flags refer to whatever instruction currently occupies that stage.

Top module: `exc_commit_ctrl`

## Requirements
- R1: A fault flagged at fetch, decode or execute causes no kill and no redirect until its instruction reaches the memory stage, three cycles after fetch. In the cycle after a taken event, the memory stage is empty and no further kill occurs.
- R2: When several stages flag the same instruction, the earliest stage wins. The synchronous cause is written as {1'b0, code}, where the code is 1 for a bad fetch address, 2 for an illegal opcode, 3 for an overflow and 4 for a bad data address.
- R3: An accepted external interrupt overrides any synchronous fault of the committing instruction. The cause is written as {1'b1, line index}, so bit CAUSE_W-1 marks an interrupt.
- R4: When several interrupt lines are raised together, the lowest-numbered line is taken.
- R5: Interrupt lines are ignored while the interrupt-enable bit is clear, and also while the memory stage holds no valid instruction.
- R6: In the commit cycle of a taken event, kill_fetch, kill_decode, kill_execute and kill_writeback are all 1, pc_sel is 1 (handler) and redirect_pc equals HANDLER_PC.
- R7: On the clock edge that ends the commit cycle, cause_q and epc_q take the cause and the PC of the committing instruction, ie_q becomes 0 and kmode_q becomes 1. This update happens once per event.
- R8: A return-from-exception at commit with no event pending does the following. It drives kill_fetch, kill_decode and kill_execute to 1 and kill_writeback to 0. It sets pc_sel to 2 (saved PC) and redirect_pc to epc_q. On the next edge, ie_q becomes 1 and kmode_q becomes 0, while cause_q and epc_q are unchanged.
- R9: An instruction that commits with no fault and no accepted interrupt raises no kill and leaves pc_sel at 0. It leaves cause_q, epc_q, ie_q and kmode_q unchanged.
- R10: After reset, cause_q and epc_q are 0, ie_q is 0, kmode_q is 1, all kill lines are 0 and pc_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | An instruction is being fetched this cycle |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_bad_pc | input | 1 | Fetch address fault |
| d_illegal | input | 1 | Decode found an undefined opcode |
| e_overflow | input | 1 | Execute found an arithmetic overflow |
| m_bad_addr | input | 1 | Memory stage found a bad data address |
| m_rfe | input | 1 | The memory-stage instruction is a return-from-exception |
| irq | input | N_IRQ | External interrupt request lines, line 0 highest priority |
| kill_fetch | output | 1 | Squash the fetch stage |
| kill_decode | output | 1 | Squash the decode stage |
| kill_execute | output | 1 | Squash the execute stage |
| kill_writeback | output | 1 | Suppress writeback of the memory-stage instruction |
| pc_sel | output | 2 | Next-PC select: 0 sequential, 1 handler, 2 saved PC |
| redirect_pc | output | PC_W | Target PC when pc_sel is not 0 |
| cause_q | output | CAUSE_W | Cause register |
| epc_q | output | PC_W | Saved exception PC |
| ie_q | output | 1 | Interrupt-enable bit |
| kmode_q | output | 1 | Kernel-mode bit |

## Verification
The assertions assume that m_rfe is raised only while the memory-stage instruction is the one the pipeline marked as a return. They also assume that pipeline flags are sampled as the level seen during the cycle, with no stall. The bench keeps to this by moving one instruction at a time through otherwise empty stages. It raises each stage flag only in the single cycle the instruction sits in that stage, and raises m_rfe only in the commit cycle of a return instruction it fetched itself. Interrupt lines are held up from fetch onward. This also exercises the cycles in which the memory stage is empty while interrupts are enabled.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    PCSEL_SEQ     = 2'd0,
    PCSEL_HANDLER = 2'd1,
    PCSEL_EPC     = 2'd2
  } pcsel_e;

  localparam int unsigned SYNC_CODE_W = 3;
  localparam int unsigned N_STAGES    = 4;

  // Synchronous fault code raised by stage s (0 fetch .. 3 memory).
  function automatic logic [SYNC_CODE_W-1:0] stage_code(input int unsigned s);
    return SYNC_CODE_W'(s + 1);
  endfunction

  // Wider of two widths, used to size the shared cause field.
  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/exc_carry_reg.sv
module exc_carry_reg #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic              in_exc,
  input  logic [CODE_W-1:0] in_code,
  input  logic [PC_W-1:0]   in_pc,
  output logic              q_valid,
  output logic              q_exc,
  output logic [CODE_W-1:0] q_code,
  output logic [PC_W-1:0]   q_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_exc   <= 1'b0;
      q_code  <= '0;
      q_pc    <= '0;
    end else if (flush) begin
      q_valid <= 1'b0;
      q_exc   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_exc   <= in_exc;
      q_code  <= in_code;
      q_pc    <= in_pc;
    end
  end

  // A fault can only ride on a live instruction.
  assert_exc_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    q_exc |-> q_valid);

endmodule

// File: rtl/exc_irq_arbiter.sv
module exc_irq_arbiter #(
  parameter int unsigned N_IRQ = 4,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [N_IRQ-1:0] req,
  output logic             grant_any,
  output logic [IDX_W-1:0] grant_idx,
  output logic [N_IRQ-1:0] grant_vec
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_IRQ-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  logic [N_IRQ-1:0] live_req;

  always_comb begin
    live_req  = accept ? req : '0;
    grant_any = |live_req;
    grant_idx = lowest_set(live_req);
    grant_vec = '0;
    if (grant_any) grant_vec[grant_idx] = 1'b1;
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~req) == '0));

  assert_no_grant_when_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> !grant_any);

endmodule

// File: rtl/exc_priv_state.sv
module exc_priv_state #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               ret,
  input  logic [CAUSE_W-1:0] cause_next,
  input  logic [PC_W-1:0]    epc_next,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q,
  output logic               ie_q,
  output logic               kmode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      ie_q    <= 1'b0;
      kmode_q <= 1'b1;
    end else if (take) begin
      cause_q <= cause_next;
      epc_q   <= epc_next;
      ie_q    <= 1'b0;
      kmode_q <= 1'b1;
    end else if (ret) begin
      ie_q    <= 1'b1;
      kmode_q <= 1'b0;
    end
  end

  assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ret) |=> ($stable(cause_q) && $stable(epc_q) && $stable(ie_q) && $stable(kmode_q)));

  assert_ret_keeps_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> ($stable(cause_q) && $stable(epc_q) && ie_q && !kmode_q));

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned N_IRQ      = 4,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180,
  localparam int unsigned IDX_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int unsigned CODE_W  = max_w(SYNC_CODE_W, IDX_W),
  localparam int unsigned CAUSE_W = CODE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               f_valid,
  input  logic [PC_W-1:0]    f_pc,
  input  logic               f_bad_pc,
  input  logic               d_illegal,
  input  logic               e_overflow,
  input  logic               m_bad_addr,
  input  logic               m_rfe,
  input  logic [N_IRQ-1:0]   irq,
  output logic               kill_fetch,
  output logic               kill_decode,
  output logic               kill_execute,
  output logic               kill_writeback,
  output logic [1:0]         pc_sel,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q,
  output logic               ie_q,
  output logic               kmode_q
);

  // Per-stage local fault flags, fetch first.
  logic [N_STAGES-1:0] stage_flag;
  assign stage_flag = {m_bad_addr, e_overflow, d_illegal, f_bad_pc};

  // Record as it leaves each stage, after the stage's own flag is merged.
  logic              mrg_valid [N_STAGES];
  logic              mrg_exc   [N_STAGES];
  logic [CODE_W-1:0] mrg_code  [N_STAGES];
  logic [PC_W-1:0]   mrg_pc    [N_STAGES];

  // Record held in the carry register in front of stages 1..3.
  logic              st_valid [1:N_STAGES-1];
  logic              st_exc   [1:N_STAGES-1];
  logic [CODE_W-1:0] st_code  [1:N_STAGES-1];
  logic [PC_W-1:0]   st_pc    [1:N_STAGES-1];

  logic flush_young;
  logic take;

  // Fetch stage: the record is born here.
  always_comb begin
    mrg_valid[0] = f_valid;
    mrg_exc[0]   = f_valid & stage_flag[0];
    mrg_code[0]  = CODE_W'(stage_code(0));
    mrg_pc[0]    = f_pc;
  end

  for (genvar s = 1; s < N_STAGES; s++) begin : g_stage
    exc_carry_reg #(.PC_W(PC_W), .CODE_W(CODE_W)) u_carry (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_young),
      .in_valid (mrg_valid[s-1]),
      .in_exc   (mrg_exc[s-1]),
      .in_code  (mrg_code[s-1]),
      .in_pc    (mrg_pc[s-1]),
      .q_valid  (st_valid[s]),
      .q_exc    (st_exc[s]),
      .q_code   (st_code[s]),
      .q_pc     (st_pc[s])
    );

    // An older fault already on the record keeps its code.
    always_comb begin
      mrg_valid[s] = st_valid[s];
      mrg_exc[s]   = st_exc[s] | (st_valid[s] & stage_flag[s]);
      mrg_code[s]  = st_exc[s] ? st_code[s] : CODE_W'(stage_code(s));
      mrg_pc[s]    = st_pc[s];
    end
  end

  // Commit point: the memory stage.
  logic              m_valid;
  logic              m_exc;
  logic [CODE_W-1:0] m_code;
  logic [PC_W-1:0]   m_pc;
  assign m_valid = mrg_valid[N_STAGES-1];
  assign m_exc   = mrg_exc[N_STAGES-1];
  assign m_code  = mrg_code[N_STAGES-1];
  assign m_pc    = mrg_pc[N_STAGES-1];

  logic             irq_take;
  logic [IDX_W-1:0] irq_idx;
  logic [N_IRQ-1:0] irq_vec;

  exc_irq_arbiter #(.N_IRQ(N_IRQ)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ie_q & m_valid),
    .req       (irq),
    .grant_any (irq_take),
    .grant_idx (irq_idx),
    .grant_vec (irq_vec)
  );

  logic               sync_take;
  logic               rfe_commit;
  logic [CAUSE_W-1:0] cause_next;

  always_comb begin
    sync_take   = m_exc;
    take        = irq_take | sync_take;
    rfe_commit  = m_valid & m_rfe & ~take;
    flush_young = take | rfe_commit;
    cause_next  = irq_take ? {1'b1, CODE_W'(irq_idx)} : {1'b0, m_code};
  end

  exc_priv_state #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .ret        (rfe_commit),
    .cause_next (cause_next),
    .epc_next   (m_pc),
    .cause_q    (cause_q),
    .epc_q      (epc_q),
    .ie_q       (ie_q),
    .kmode_q    (kmode_q)
  );

  always_comb begin
    kill_fetch     = flush_young;
    kill_decode    = flush_young;
    kill_execute   = flush_young;
    kill_writeback = take;
    if (take) begin
      pc_sel      = PCSEL_HANDLER;
      redirect_pc = HANDLER_PC;
    end else if (rfe_commit) begin
      pc_sel      = PCSEL_EPC;
      redirect_pc = epc_q;
    end else begin
      pc_sel      = PCSEL_SEQ;
      redirect_pc = '0;
    end
  end

  assert_take_records_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(m_pc)) && (cause_q == $past(cause_next)) && !ie_q && kmode_q);

  assert_quiet_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !kill_writeback && (pc_sel == PCSEL_SEQ));

  assert_irq_beats_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && sync_take) |=> cause_q[CAUSE_W-1]);

  assert_masked_irq_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !m_exc) |-> !kill_writeback);

  assert_stall_free_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill_writeback |-> (kill_fetch && kill_decode && kill_execute));

endmodule

// File: tb/exc_commit_ctrl_bench.sv
`timescale 1ns/1ps
module exc_commit_ctrl_bench;
  localparam int unsigned PC_W = 32;
  localparam int unsigned N_IRQ = 4;
  localparam logic [PC_W-1:0] HPC = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_valid = 0, f_bad_pc = 0, d_illegal = 0, e_overflow = 0, m_bad_addr = 0, m_rfe = 0;
  logic [PC_W-1:0] f_pc = '0;
  logic [N_IRQ-1:0] irq = '0;
  logic kill_fetch, kill_decode, kill_execute, kill_writeback;
  logic [1:0] pc_sel;
  logic [PC_W-1:0] redirect_pc, epc_q;
  logic [3:0] cause_q;
  logic ie_q, kmode_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [PC_W-1:0] exp_epc = '0;
  logic [3:0] exp_cause = '0;

  always #4 clk = ~clk;

  exc_commit_ctrl #(.PC_W(PC_W), .N_IRQ(N_IRQ), .HANDLER_PC(HPC)) u_exc_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_bad_pc(f_bad_pc),
    .d_illegal(d_illegal), .e_overflow(e_overflow), .m_bad_addr(m_bad_addr),
    .m_rfe(m_rfe), .irq(irq), .kill_fetch(kill_fetch), .kill_decode(kill_decode),
    .kill_execute(kill_execute), .kill_writeback(kill_writeback), .pc_sel(pc_sel),
    .redirect_pc(redirect_pc), .cause_q(cause_q), .epc_q(epc_q), .ie_q(ie_q),
    .kmode_q(kmode_q));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] kills();
    return {kill_fetch, kill_decode, kill_execute, kill_writeback};
  endfunction

  // Return-from-exception: fetch, then commit three cycles later.
  task automatic do_rfe();
    @(negedge clk); f_valid = 1; f_pc = 32'hA000;
    @(negedge clk); f_valid = 0;
    @(negedge clk);
    @(negedge clk); m_rfe = 1; #1;
    chk("R8 kills", kills(), 4'b1110);
    chk("R8 pc_sel", pc_sel, 2);
    chk("R8 redirect", redirect_pc, exp_epc);
    @(posedge clk); #1; m_rfe = 0;
    chk("R8 ie/kmode", {ie_q, kmode_q}, 2'b10);
    chk("R8 cause/epc kept", {cause_q, epc_q}, {exp_cause, exp_epc});
  endtask

  // One instruction with per-stage flags b[0..3] and interrupt pattern pat.
  task automatic run_one(input logic [3:0] b, input logic [3:0] pat, input logic [PC_W-1:0] pc,
                         input logic ie_now);
    logic take;
    logic [3:0] cz;
    @(negedge clk); f_valid = 1; f_pc = pc; f_bad_pc = b[0]; irq = pat; #1;
    chk("R1 R5 quiet c0", kills(), 0);
    @(negedge clk); f_valid = 0; f_bad_pc = 0; d_illegal = b[1]; #1;
    chk("R1 R5 quiet c1", kills(), 0);
    @(negedge clk); d_illegal = 0; e_overflow = b[2]; #1;
    chk("R1 R5 quiet c2", kills(), 0);
    @(negedge clk); e_overflow = 0; m_bad_addr = b[3]; #1;
    take = (ie_now && pat != 0) || (b != 0);
    if (ie_now && pat != 0)
      cz = pat[0] ? 4'h8 : pat[1] ? 4'h9 : pat[2] ? 4'hA : 4'hB;   // R3 R4
    else
      cz = b[0] ? 4'h1 : b[1] ? 4'h2 : b[2] ? 4'h3 : 4'h4;         // R2
    if (take) begin
      chk("R6 kills", kills(), 4'b1111);
      chk("R6 pc_sel", pc_sel, 1);
      chk("R6 redirect", redirect_pc, HPC);
    end else begin
      chk("R9 R5 kills", kills(), 0);
      chk("R9 pc_sel", pc_sel, 0);
    end
    @(posedge clk); #1;
    m_bad_addr = 0; irq = 0;
    if (take) begin
      exp_cause = cz; exp_epc = pc;
      chk("R2 R3 R4 R7 cause", cause_q, exp_cause);
      chk("R7 epc", epc_q, exp_epc);
      chk("R7 ie/kmode", {ie_q, kmode_q}, 2'b01);
      @(negedge clk);
      chk("R1 after take", kills(), 0);
    end else begin
      chk("R9 state", {cause_q, epc_q, ie_q, kmode_q}, {exp_cause, exp_epc, ie_now, ~ie_now});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 regs", {cause_q, epc_q, ie_q, kmode_q}, {4'h0, 32'h0, 1'b0, 1'b1});
    chk("R10 outs", {kills(), pc_sel}, 6'b0);
    @(negedge clk); rst_n = 1;
    // Interrupts masked after reset: R5.
    run_one(4'b0000, 4'b1010, 32'h0000_0400, 1'b0);
    run_one(4'b0000, 4'b0001, 32'h0000_0404, 1'b0);
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 16; p++) begin
        do_rfe();
        run_one(4'(f), 4'(p), 32'h0000_1000 + 32'(f * 64 + p * 4), 1'b1);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule